// File: doc/BRIEF.md
# Register-Level Serial Configuration Port

This block is a serial configuration slave that works on whole registers. The host opens every access with one instruction byte. That byte carries the direction flag and a five-bit register address. The controller then takes over addressing. It looks up how many bytes the selected register holds and counts through them from the most significant byte down. The host never sends byte addresses. An access is finished only when every byte of the register has been shifted. After that, the next byte on the line is taken as a new instruction, even while chip select stays low. The only way to cut an access short is the abort input. It throws away the current access and leaves the port waiting for an instruction.

Written data does not act at once. Each completed byte lands in a buffer copy of its register. The live (active) copy changes only when the I/O update strobe is used. The strobe is first registered on a rising edge of the sync clock. On the next rising edge, the whole buffer set is copied into the active set. Reads always return the active contents. Several ports that share the sync clock and the strobe therefore switch to new settings in the same cycle.

All serial inputs (serial clock, chip select, data in, abort) pass through a synchronizer into the sync clock domain. The serial clock is then handled as a sampled signal, so the sync clock must run several times faster than the serial clock.

Top module: `serial_cfg_port`

## Requirements
- R1: After reset, every active register reads as zero and the serial data output is low.
- R2: The instruction byte is shifted most significant bit first. Bit 7 set means read and bit 7 clear means write. Bits 4..0 give the register address. Bits 6 and 5 have no effect.
- R3: A completed write byte changes only the buffer copy. The active register output keeps its old value until an update.
- R4: The update strobe is sampled on a sync clock rising edge. On the next sync clock rising edge, all buffer registers are copied into the active registers. A strobe that stays high causes only one copy per low-to-high change.
- R5: The number of data bytes per access comes from a fixed table: address 0 has 4 bytes, 1 has 3, 2 has 2, 3 has 4, 4 has 1 and 5 has 2. The byte after the last data byte is the next instruction, even with chip select held low.
- R6: Data bytes go most significant byte first. The first data byte after the instruction maps to the highest byte of the register. Register bytes above the register's length stay zero.
- R7: A read returns the active value, not a pending buffered value. The output bit changes only after falling serial clock edges and stays steady while the serial clock is high.
- R8: Addresses 6 to 31 are accepted and take a single data byte. A write to them changes no register. A read from them returns zero.
- R9: The abort input ends the access in progress and returns the port to expecting an instruction byte. Buffer bytes completed before the abort keep their new values. A partly shifted byte is dropped.
- R10: While chip select is high, serial clock edges are ignored. The access resumes at the same bit when chip select goes low again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sync_clk | input | 1 | Sync clock. Clocks all logic and samples the update strobe. |
| rst | input | 1 | Synchronous active-high reset. |
| ser_clk | input | 1 | Serial clock from the host. Input bits are taken on its rising edges. |
| ser_csn | input | 1 | Chip select, active low. |
| ser_din | input | 1 | Serial data in, MSB first. |
| io_update | input | 1 | Update strobe that commits the buffers to the active registers. |
| xfer_abort | input | 1 | Abort request. Cancels the current access. |
| ser_dout | output | 1 | Serial read data. Changes after falling serial clock edges. |
| active_regs | output | 192 | Active register contents. Register r sits at bits [32r+31:32r]. |

## Verification
The hardest state to reach from the ports is an access stopped at an odd point. Two cases matter: an abort arriving three bits into the third byte of a four-byte write, and chip select going high in the middle of a byte while the serial clock keeps toggling. The bench builds both by driving the serial lines bit by bit with its own shift task. It stops partway, applies the abort or the deselect with stray clock edges, and then goes on. Right after the abort it starts a new instruction in the same select window, and right after the resumed access it sends a following write. A commit then shows at the output which buffer bytes survived and whether the port was in step.

// File: rtl/spc_pkg.sv
package spc_pkg;

    localparam int ADDR_W    = 5;
    localparam int NUM_REGS  = 6;
    localparam int MAX_BYTES = 4;
    localparam int REG_W     = MAX_BYTES * 8;
    localparam int BIDX_W    = $clog2(MAX_BYTES);
    localparam int BCNT_W    = BIDX_W + 1;
    localparam int RD_FLAG_BIT = 7;

    typedef enum logic {
        PH_INSTR = 1'b0,
        PH_DATA  = 1'b1
    } phase_e;

    typedef struct packed {
        logic              en;
        logic [ADDR_W-1:0] addr;
        logic [BIDX_W-1:0] idx;
        logic [7:0]        data;
    } wr_req_t;

    // Bytes per register; unmapped addresses move a single byte.
    function automatic logic [BCNT_W-1:0] reg_len(input logic [ADDR_W-1:0] a);
        case (a)
            ADDR_W'(0): reg_len = BCNT_W'(4);
            ADDR_W'(1): reg_len = BCNT_W'(3);
            ADDR_W'(2): reg_len = BCNT_W'(2);
            ADDR_W'(3): reg_len = BCNT_W'(4);
            ADDR_W'(4): reg_len = BCNT_W'(1);
            ADDR_W'(5): reg_len = BCNT_W'(2);
            default:    reg_len = BCNT_W'(1);
        endcase
    endfunction

endpackage

// File: rtl/spc_in_sync.sv
module spc_in_sync #(
    parameter int          WIDTH   = 4,
    parameter int          STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [STAGES-1:0][WIDTH-1:0] stg;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) stg[s] <= RST_VAL;
        end else begin
            stg[0] <= d;
            for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/spc_shift_ctrl.sv
module spc_shift_ctrl
    import spc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sclk_s,
    input  logic              csn_s,
    input  logic              sdi_s,
    input  logic              abort_s,
    input  logic [7:0]        rd_byte,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [BIDX_W-1:0] rd_idx,
    output wr_req_t           wr,
    output logic              sdo,
    output logic              data_phase,
    output logic [2:0]        bit_pos
);

    phase_e            phase;
    logic              sclk_d;
    logic [2:0]        bit_cnt;
    logic [7:0]        sh;
    logic [7:0]        rd_sh;
    logic              rd_mode;
    logic [ADDR_W-1:0] addr;
    logic [BCNT_W-1:0] left;

    logic              live, rise, fall, byte_end;
    logic [7:0]        sh_nx;
    logic [ADDR_W-1:0] ins_addr;
    logic              ins_rd;

    assign live     = !csn_s && !abort_s;
    assign rise     = live && sclk_s && !sclk_d;
    assign fall     = live && !sclk_s && sclk_d;
    assign byte_end = rise && (bit_cnt == 3'd7);
    assign sh_nx    = {sh[6:0], sdi_s};
    assign ins_addr = sh_nx[ADDR_W-1:0];
    assign ins_rd   = sh_nx[RD_FLAG_BIT];

    always_comb begin
        if (phase == PH_INSTR) begin
            rd_addr = ins_addr;
            rd_idx  = BIDX_W'(reg_len(ins_addr) - BCNT_W'(1));
        end else begin
            rd_addr = addr;
            rd_idx  = BIDX_W'(left - BCNT_W'(2));
        end
        wr.en   = byte_end && (phase == PH_DATA) && !rd_mode;
        wr.addr = addr;
        wr.idx  = BIDX_W'(left - BCNT_W'(1));
        wr.data = sh_nx;
    end

    always_ff @(posedge clk) begin
        if (rst) sclk_d <= 1'b0;
        else     sclk_d <= sclk_s;
    end

    always_ff @(posedge clk) begin
        if (rst || abort_s) begin
            phase   <= PH_INSTR;
            bit_cnt <= '0;
            sh      <= '0;
            rd_sh   <= '0;
            sdo     <= 1'b0;
            rd_mode <= 1'b0;
            addr    <= '0;
            left    <= '0;
        end else if (rise) begin
            sh      <= sh_nx;
            bit_cnt <= bit_cnt + 3'd1;
            if (byte_end) begin
                if (phase == PH_INSTR) begin
                    phase   <= PH_DATA;
                    rd_mode <= ins_rd;
                    addr    <= ins_addr;
                    left    <= reg_len(ins_addr);
                    rd_sh   <= ins_rd ? rd_byte : 8'h00;
                end else begin
                    left <= left - BCNT_W'(1);
                    if (left == BCNT_W'(1)) begin
                        phase   <= PH_INSTR;
                        rd_mode <= 1'b0;
                        rd_sh   <= 8'h00;
                    end else begin
                        rd_sh <= rd_mode ? rd_byte : 8'h00;
                    end
                end
            end
        end else if (fall) begin
            sdo   <= rd_sh[7];
            rd_sh <= {rd_sh[6:0], 1'b0};
        end
    end

    assign data_phase = (phase == PH_DATA);
    assign bit_pos    = bit_cnt;

endmodule

// File: rtl/spc_reg_bank.sv
module spc_reg_bank
    import spc_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  wr_req_t                   wr,
    input  logic                      io_update,
    input  logic [ADDR_W-1:0]         rd_addr,
    input  logic [BIDX_W-1:0]         rd_idx,
    output logic [7:0]                rd_byte,
    output logic [NUM_REGS*REG_W-1:0] active_flat
);

    logic upd_q, upd_qq, commit;
    logic [REG_W-1:0] act_arr [NUM_REGS];

    always_ff @(posedge clk) begin
        if (rst) begin
            upd_q  <= 1'b0;
            upd_qq <= 1'b0;
        end else begin
            upd_q  <= io_update;
            upd_qq <= upd_q;
        end
    end

    assign commit = upd_q && !upd_qq;

    generate
        for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
            logic [REG_W-1:0] buf_q;
            logic [REG_W-1:0] act_q;

            always_ff @(posedge clk) begin
                if (rst) begin
                    buf_q <= '0;
                    act_q <= '0;
                end else begin
                    if (wr.en && (wr.addr == ADDR_W'(r)))
                        buf_q[{wr.idx, 3'b000} +: 8] <= wr.data;
                    if (commit)
                        act_q <= buf_q;
                end
            end

            assign act_arr[r] = act_q;
            assign active_flat[r*REG_W +: REG_W] = act_q;
        end
    endgenerate

    always_comb begin
        rd_byte = 8'h00;
        for (int r = 0; r < NUM_REGS; r++) begin
            if (rd_addr == ADDR_W'(r))
                rd_byte = act_arr[r][{rd_idx, 3'b000} +: 8];
        end
    end

endmodule

// File: rtl/serial_cfg_port.sv
module serial_cfg_port
    import spc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                      sync_clk,
    input  logic                      rst,
    input  logic                      ser_clk,
    input  logic                      ser_csn,
    input  logic                      ser_din,
    input  logic                      io_update,
    input  logic                      xfer_abort,
    output logic                      ser_dout,
    output logic [NUM_REGS*REG_W-1:0] active_regs
);

    logic [3:0]        raw_in, syn_in;
    logic              sclk_s, csn_s, sdi_s, abort_s;
    logic [7:0]        rd_byte;
    logic [ADDR_W-1:0] rd_addr;
    logic [BIDX_W-1:0] rd_idx;
    wr_req_t           wr_bus;
    logic              data_phase;
    logic [2:0]        bit_pos;

    assign raw_in = {xfer_abort, ser_din, ser_csn, ser_clk};

    spc_in_sync #(
        .WIDTH  (4),
        .STAGES (SYNC_STAGES),
        .RST_VAL(4'b0010)
    ) u_sync (
        .clk(sync_clk),
        .rst(rst),
        .d  (raw_in),
        .q  (syn_in)
    );

    assign {abort_s, sdi_s, csn_s, sclk_s} = syn_in;

    spc_shift_ctrl u_ctrl (
        .clk       (sync_clk),
        .rst       (rst),
        .sclk_s    (sclk_s),
        .csn_s     (csn_s),
        .sdi_s     (sdi_s),
        .abort_s   (abort_s),
        .rd_byte   (rd_byte),
        .rd_addr   (rd_addr),
        .rd_idx    (rd_idx),
        .wr        (wr_bus),
        .sdo       (ser_dout),
        .data_phase(data_phase),
        .bit_pos   (bit_pos)
    );

    spc_reg_bank u_bank (
        .clk        (sync_clk),
        .rst        (rst),
        .wr         (wr_bus),
        .io_update  (io_update),
        .rd_addr    (rd_addr),
        .rd_idx     (rd_idx),
        .rd_byte    (rd_byte),
        .active_flat(active_regs)
    );

endmodule

// File: rtl/serial_cfg_port_chk.sv
module serial_cfg_port_chk
    import spc_pkg::*;
(
    input logic                      clk,
    input logic                      rst,
    input logic                      abort_s,
    input logic                      csn_s,
    input logic                      data_phase,
    input logic [2:0]                bit_pos,
    input logic                      io_update,
    input logic [NUM_REGS*REG_W-1:0] active_regs
);

    logic [2:0] cyc;

    always_ff @(posedge clk) begin
        if (rst)              cyc <= '0;
        else if (cyc != 3'd7) cyc <= cyc + 3'd1;
    end

    AST_ABORT_RESTART: assert property (@(posedge clk) disable iff (rst)
        abort_s |=> (!data_phase && bit_pos == 3'd0)); // R9

    AST_DESELECT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (csn_s && !abort_s) |=> ($stable(bit_pos) && $stable(data_phase))); // R10

    AST_COMMIT_TIMING: assert property (@(posedge clk) disable iff (rst)
        (cyc >= 3'd4 && !$stable(active_regs)) |-> ($past(io_update, 2) && !$past(io_update, 3))); // R4

    AST_BIT_STEP: assert property (@(posedge clk) disable iff (rst)
        (cyc != 3'd0 && !$stable(bit_pos) && !$past(abort_s)) |-> (bit_pos == 3'($past(bit_pos) + 3'd1))); // R2

    AST_INSTR_LENGTH: assert property (@(posedge clk) disable iff (rst)
        (cyc != 3'd0 && $rose(data_phase)) |-> (bit_pos == 3'd0 && $past(bit_pos) == 3'd7)); // R2

endmodule

bind serial_cfg_port serial_cfg_port_chk chk_i (
    .clk        (sync_clk),
    .rst        (rst),
    .abort_s    (abort_s),
    .csn_s      (csn_s),
    .data_phase (data_phase),
    .bit_pos    (bit_pos),
    .io_update  (io_update),
    .active_regs(active_regs)
);

// File: tb/serial_cfg_port_tb_top.sv
`timescale 1ns/1ps
module serial_cfg_port_tb_top;

    localparam int HALF = 8;
    localparam int NREG = 6;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         ser_clk = 1'b0;
    logic         ser_csn = 1'b1;
    logic         ser_din = 1'b0;
    logic         io_update = 1'b0;
    logic         xfer_abort = 1'b0;
    logic         ser_dout;
    logic [191:0] active_regs;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 0;
    bit chk_sdo = 0;

    logic [31:0] m_buf [NREG];
    logic [31:0] m_act [NREG];
    logic [7:0]  exp_q [$];
    string       tag_q [$];
    logic [7:0]  rx_byte;
    event        rx_ev;

    always #5 clk = ~clk;

    serial_cfg_port dut_i (
        .sync_clk   (clk),
        .rst        (rst),
        .ser_clk    (ser_clk),
        .ser_csn    (ser_csn),
        .ser_din    (ser_din),
        .io_update  (io_update),
        .xfer_abort (xfer_abort),
        .ser_dout   (ser_dout),
        .active_regs(active_regs)
    );

    function automatic int len_of(input logic [4:0] a);
        case (a)
            5'd0: return 4;
            5'd1: return 3;
            5'd2: return 2;
            5'd3: return 4;
            5'd4: return 1;
            5'd5: return 2;
            default: return 1;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic shift_bits(input logic [7:0] v, input int hi, input int lo, output logic [7:0] rx);
        rx = 8'h00;
        for (int i = hi; i >= lo; i--) begin
            ser_din = v[i];
            wait_clk(HALF);
            rx[i] = ser_dout;
            ser_clk = 1'b1;
            wait_clk(HALF);
            if (chk_sdo) check("R7 dout steady while clock high", {31'd0, ser_dout}, {31'd0, rx[i]});
            ser_clk = 1'b0;
        end
    endtask

    task automatic shift_byte(input logic [7:0] v);
        logic [7:0] dummy;
        shift_bits(v, 7, 0, dummy);
    endtask

    task automatic sel_on();
        ser_csn = 1'b0;
        wait_clk(3);
    endtask

    task automatic sel_off();
        wait_clk(HALF);
        ser_csn = 1'b1;
        wait_clk(6);
    endtask

    task automatic wr_reg(input logic [4:0] a, input logic [31:0] d, input logic [1:0] spare);
        int n;
        n = len_of(a);
        shift_byte({1'b0, spare, a});
        for (int b = n - 1; b >= 0; b--) begin
            shift_byte(d[8*b +: 8]);
            if (a < 5'd6) m_buf[a][8*b +: 8] = d[8*b +: 8];
        end
    endtask

    task automatic rd_reg(input logic [4:0] a, input string tag);
        int n;
        logic [7:0] rx;
        n = len_of(a);
        shift_byte({1'b1, 2'b00, a});
        for (int b = n - 1; b >= 0; b--) begin
            exp_q.push_back(a < 5'd6 ? m_act[a][8*b +: 8] : 8'h00);
            tag_q.push_back(tag);
            chk_sdo = 1'b1;
            shift_bits(8'h00, 7, 0, rx);
            chk_sdo = 1'b0;
            rx_byte = rx;
            ->rx_ev;
        end
    endtask

    task automatic commit();
        io_update = 1'b1;
        wait_clk(2);
        io_update = 1'b0;
        wait_clk(4);
        for (int r = 0; r < NREG; r++) m_act[r] = m_buf[r];
    endtask

    task automatic check_regs(input string req);
        for (int r = 0; r < NREG; r++) check(req, active_regs[r*32 +: 32], m_act[r]);
    endtask

    // Monitor: compares each received read byte with the queued expectation.
    initial begin
        forever begin
            @(rx_ev);
            if (exp_q.size() == 0) begin
                check("R7 unexpected read byte", {24'd0, rx_byte}, 32'hFFFF_FFFF);
            end else begin
                logic [7:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(t, {24'd0, rx_byte}, {24'd0, e});
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    endtask

    initial begin
        wait_clk(150000);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] dummy;
        for (int r = 0; r < NREG; r++) begin
            m_buf[r] = 32'd0;
            m_act[r] = 32'd0;
        end
        wait_clk(5);
        rst = 1'b0;
        wait_clk(4);

        // R1: reset state
        check_regs("R1 reset value");
        check("R1 dout low", {31'd0, ser_dout}, 32'd0);

        // R3: write lands in buffer only
        sel_on();
        wr_reg(5'd0, 32'hA1B2C3D4, 2'b00);
        sel_off();
        check("R3 active unchanged before update", active_regs[31:0], 32'd0);

        // R4 / R6: commit and byte order
        commit();
        check("R6 byte order reg0", active_regs[31:0], 32'hA1B2C3D4);
        check_regs("R4 commit");

        // R5: several registers back to back under one select
        sel_on();
        wr_reg(5'd4, 32'h0000005E, 2'b00);
        wr_reg(5'd1, 32'h00112233, 2'b00);
        wr_reg(5'd2, 32'h0000BEEF, 2'b00);
        sel_off();
        commit();
        check_regs("R5 length table");

        // R4: strobe held high gives one copy only
        io_update = 1'b1;
        wait_clk(4);
        for (int r = 0; r < NREG; r++) m_act[r] = m_buf[r];
        sel_on();
        wr_reg(5'd4, 32'h00000077, 2'b00);
        sel_off();
        wait_clk(4);
        check("R4 held strobe no second copy", active_regs[4*32 +: 32], 32'h0000005E);
        io_update = 1'b0;
        wait_clk(3);
        commit();
        check("R4 new edge commits", active_regs[4*32 +: 32], 32'h00000077);

        // R7: read returns active, not pending buffer
        sel_on();
        rd_reg(5'd0, "R7 read reg0");
        sel_off();
        sel_on();
        wr_reg(5'd1, 32'h00445566, 2'b00);
        rd_reg(5'd1, "R7 read active not buffer");
        sel_off();

        // R8: unmapped address, one byte, discarded
        sel_on();
        wr_reg(5'd9, 32'h000000FF, 2'b00);
        wr_reg(5'd5, 32'h00001357, 2'b00);
        sel_off();
        commit();
        check_regs("R8 unmapped write discarded");
        sel_on();
        rd_reg(5'd20, "R8 unmapped read zero");
        rd_reg(5'd4, "R8 single byte then instruction");
        sel_off();

        // R2: spare instruction bits ignored
        sel_on();
        wr_reg(5'd3, 32'h0BADCAFE, 2'b11);
        sel_off();
        commit();
        check("R2 spare bits ignored", active_regs[3*32 +: 32], 32'h0BADCAFE);

        // R9: abort mid-byte
        sel_on();
        shift_byte(8'h03);
        shift_byte(8'h12);
        shift_byte(8'h34);
        shift_bits(8'h56, 7, 5, dummy);
        wait_clk(4);
        xfer_abort = 1'b1;
        wait_clk(4);
        xfer_abort = 1'b0;
        wait_clk(4);
        m_buf[3] = 32'h1234CAFE;
        wr_reg(5'd4, 32'h00000099, 2'b00);
        sel_off();
        commit();
        check("R9 completed bytes kept", active_regs[3*32 +: 32], 32'h1234CAFE);
        check("R9 next instruction accepted", active_regs[4*32 +: 32], 32'h00000099);

        // R10: deselect mid-byte, stray clocks ignored
        sel_on();
        shift_byte(8'h02);
        shift_byte(8'hC0);
        shift_bits(8'h3D, 7, 4, dummy);
        wait_clk(HALF);
        ser_csn = 1'b1;
        wait_clk(6);
        for (int k = 0; k < 3; k++) begin
            ser_din = k[0];
            ser_clk = 1'b1;
            wait_clk(HALF);
            ser_clk = 1'b0;
            wait_clk(HALF);
        end
        ser_csn = 1'b0;
        wait_clk(6);
        shift_bits(8'h3D, 3, 0, dummy);
        m_buf[2] = 32'h0000C03D;
        wr_reg(5'd4, 32'h00000042, 2'b00);
        sel_off();
        commit();
        check("R10 resumed access", active_regs[2*32 +: 32], 32'h0000C03D);
        check("R10 following write aligned", active_regs[4*32 +: 32], 32'h00000042);
        check_regs("R6 final register set");

        // R6: readback of committed multi-byte registers
        sel_on();
        rd_reg(5'd1, "R6 read reg1");
        rd_reg(5'd3, "R6 read reg3");
        sel_off();
        wait_clk(4);
        check("R7 all expected bytes seen", exp_q.size(), 32'd0);

        finish_run();
    end

endmodule